// File: doc/BRIEF.md
# Transport stream ring DMA writer

The block turns an incoming byte stream of fixed-length transport packets into word writes toward memory. Bytes are packed four at a time, little-endian, into 32-bit words. Each word is written at the current head address of a circular buffer, and the head then moves forward by one word. Software programs the ring base and a packed geometry word. The geometry gives the packet size, the packets per block and the block count, and the ring length is the product of the three. The head returns to the base after the last word of the ring.

A control/status word holds three bits: a run enable, a sticky overflow error and a pending-interrupt flag. None of them is ever written directly. Software sets bits through a set port and clears them through a clear port. The pending flag drives the interrupt output, which a top-level aggregator masks per channel. The flag is raised when a full block has been written, or when the stream stalls for longer than a programmable number of clock periods after data has arrived. A small holding buffer absorbs short memory stalls. When it is full, completed words are discarded and the error bit records the loss.

Top module: `tsr_ring_writer`

## Requirements
- R1: After reset the control/status word reads 0, the head low word reads 0, mem_req is low and irq is low.
- R2: The control/status word has three writable bits: RUN at bit 0, ERR at bit 1 and IRQ at bit 9 (mask 0x203). Register index 0 is the set port, where ones set those bits. Index 1 is the clear port, where ones clear them. Other bits read 0, and a read of index 0 or 1 returns the word.
- R3: While RUN is 1, each input byte is taken in. Bytes are packed with the first byte in bits 7:0 of a 32-bit word. Each word is written at the head, and the head then moves forward by 4. While RUN is 0, input bytes are ignored.
- R4: The geometry register (index 4) holds the packet size in bits 7:0, the packets per block in bits 15:8 and the block count in bits 31:24. Ring length in bytes is the product of the three fields. The head returns to the base after the word that ends the ring.
- R5: The ring base is the start-low register (index 2) with bits 31:30 and 1:0 taken as zero. Writing index 2 moves the head to the new base. The head low word is read at index 6. Index 7 reads back the start-high register (index 3).
- R6: IRQ (bit 9) sets when the memory write that completes a block is acknowledged. The irq output equals bit 9.
- R7: The timeout register (index 5) reloads a counter on every acknowledged write. While RUN is 1 and a word has been written since IRQ last set, the counter counts down once per clock. IRQ sets T clocks after the write, where T is the timeout value. A value of 0 never fires, and with no data since the last interrupt nothing fires.
- R8: A word completed while the holding buffer is full at the start of that cycle is discarded and sets ERR (bit 1). ERR stays set until it is cleared through the clear port.
- R9: Clearing RUN lets a write already requested finish, starts no new request and keeps the head. Setting RUN again resumes from that head.
- R10: When hardware sets ERR or IRQ in the same cycle that the clear port clears that bit, the bit ends up set.
- R11: mem_req stays high with mem_addr and mem_wdata unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input stream byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory word write request |
| mem_addr | output | 32 | Byte address of the word being written |
| mem_wdata | output | 32 | Word being written |
| mem_ack | input | 1 | Memory accepted the request |
| irq | output | 1 | Pending interrupt (IRQ bit) |

## Verification
Two updates can land on the error bit in the same cycle. One is the overflow that sets it, from a word completing while the holding buffer is full. The other is a clear-port write that clears it. The bench provokes this by holding mem_ack low until the buffer fills, clearing ERR, and then driving the byte that completes a word in the same cycle as a clear-port write of bit 1. It judges the result by reading the word back, where ERR must still be 1. A behavioural model also predicts the interrupt and memory outputs cycle by cycle and is compared with the design on every clock.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   localparam int CTL_RUN = 0;
   localparam int CTL_ERR = 1;
   localparam int CTL_IRQ = 9;
   localparam logic [31:0] CTL_WMASK = 32'h0000_0203;

   localparam logic [2:0] RA_SET     = 3'd0;
   localparam logic [2:0] RA_CLR     = 3'd1;
   localparam logic [2:0] RA_BASE_LO = 3'd2;
   localparam logic [2:0] RA_BASE_HI = 3'd3;
   localparam logic [2:0] RA_GEOM    = 3'd4;
   localparam logic [2:0] RA_TMO     = 3'd5;
   localparam logic [2:0] RA_HEAD_LO = 3'd6;
   localparam logic [2:0] RA_HEAD_HI = 3'd7;
endpackage

// File: rtl/tsr_byte_packer.sv
module tsr_byte_packer #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              buf_full,
   output logic              word_push,
   output logic              word_drop,
   output logic [DATA_W-1:0] word_data
);
   localparam int BYTES = DATA_W / 8;
   localparam int BCW   = $clog2(BYTES);

   logic [DATA_W-1:0] acc_q;
   logic [BCW-1:0]    bcnt_q;
   logic              take, last;

   assign take = in_valid && run;
   assign last = take && (bcnt_q == BCW'(BYTES - 1));

   always_comb begin
      word_data = acc_q;
      word_data[8*bcnt_q +: 8] = in_data;
   end

   assign word_push = last && !buf_full;
   assign word_drop = last && buf_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         bcnt_q <= '0;
      end else if (take) begin
         acc_q[8*bcnt_q +: 8] <= in_data;
         bcnt_q <= last ? '0 : bcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tsr_hold_fifo.sv
module tsr_hold_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("tsr_hold_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic         valid_q;
      logic [W-1:0] data_q;
      assign full  = valid_q;
      assign empty = !valid_q;
      assign dout  = data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
         end else if (push) begin
            valid_q <= 1'b1;
            data_q  <= din;
         end else if (pop) begin
            valid_q <= 1'b0;
         end
      end
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      logic [W-1:0]  mem_q [DEPTH];
      logic [PW-1:0] wp_q, rp_q;
      logic [CW-1:0] cnt_q;

      assign full  = (cnt_q == CW'(DEPTH));
      assign empty = (cnt_q == '0);
      assign dout  = mem_q[rp_q];

      always_ff @(posedge clk) begin
         if (push) mem_q[wp_q] <= din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            case ({push, pop})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end

   // R8
   no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R8
   no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/tsr_mem_issue.sv
module tsr_mem_issue #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_dout,
   input  logic [ADDR_W-1:0] head_addr,
   output logic              pop,
   output logic              done,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack
);
   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              load;

   assign load      = !busy_q && run && !fifo_empty;
   assign pop       = load;
   assign done      = busy_q && mem_ack;
   assign mem_req   = busy_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         addr_q <= head_addr;
         data_q <= fifo_dout;
      end else if (done) begin
         busy_q <= 1'b0;
      end
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
   // R9
   no_start_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !$rose(mem_req));
endmodule

// File: rtl/tsr_ctl_regs.sv
module tsr_ctl_regs
   import tsr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BYTES     = 4,
   parameter int TMO_W     = 32,
   parameter int GF_W      = 8,
   parameter int BASE_KEEP = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              done,
   input  logic              drop,
   output logic              run,
   output logic              irq,
   output logic [ADDR_W-1:0] head_addr
);
   localparam int BLK_W = 2 * GF_W;
   localparam int OFF_W = 3 * GF_W;

   logic [31:0]       ctl_q, base_lo_q, base_hi_q, geom_q, tmo_q;
   logic [OFF_W-1:0]  off_q;
   logic [BLK_W-1:0]  boff_q;
   logic [TMO_W-1:0]  tcnt_q;
   logic              dirty_q;

   logic [GF_W-1:0]   pkt_sz, pkt_per_blk, blk_cnt;
   logic [BLK_W-1:0]  blk_bytes;
   logic [OFF_W-1:0]  ring_len;
   logic [OFF_W:0]    off_nx;
   logic [BLK_W:0]    boff_nx;
   logic              ring_wrap, blk_last, tmo_fire, evt_irq;
   logic              wr_set, wr_clr, wr_base_lo;
   logic [31:0]       sw_set, sw_clr, hw_set, ctl_d;
   logic [ADDR_W-1:0] base_eff;

   assign pkt_sz      = geom_q[GF_W-1:0];
   assign pkt_per_blk = geom_q[2*GF_W-1:GF_W];
   assign blk_cnt     = geom_q[31 -: GF_W];
   assign blk_bytes   = BLK_W'(pkt_sz) * BLK_W'(pkt_per_blk);
   assign ring_len    = OFF_W'(blk_bytes) * OFF_W'(blk_cnt);

   assign off_nx    = {1'b0, off_q} + (OFF_W+1)'(BYTES);
   assign boff_nx   = {1'b0, boff_q} + (BLK_W+1)'(BYTES);
   assign ring_wrap = off_nx >= {1'b0, ring_len};
   assign blk_last  = done && (boff_nx >= {1'b0, blk_bytes});
   assign tmo_fire  = !done && run && dirty_q && (tcnt_q == TMO_W'(1));
   assign evt_irq   = blk_last || tmo_fire;

   assign wr_set     = reg_wr && (reg_addr == RA_SET);
   assign wr_clr     = reg_wr && (reg_addr == RA_CLR);
   assign wr_base_lo = reg_wr && (reg_addr == RA_BASE_LO);
   assign sw_set     = wr_set ? (reg_wdata & CTL_WMASK) : '0;
   assign sw_clr     = wr_clr ? (reg_wdata & CTL_WMASK) : '0;

   always_comb begin
      hw_set = '0;
      hw_set[CTL_IRQ] = evt_irq;
      hw_set[CTL_ERR] = drop;
   end
   assign ctl_d = ((ctl_q | sw_set) & ~sw_clr) | hw_set;

   assign base_eff  = ADDR_W'(base_lo_q[BASE_KEEP-1:0]) & ~ADDR_W'(BYTES - 1);
   assign head_addr = base_eff + ADDR_W'(off_q);
   assign run       = ctl_q[CTL_RUN];
   assign irq       = ctl_q[CTL_IRQ];

   always_comb begin
      case (reg_addr)
         RA_SET, RA_CLR: reg_rdata = ctl_q;
         RA_BASE_LO:     reg_rdata = base_lo_q;
         RA_BASE_HI:     reg_rdata = base_hi_q;
         RA_GEOM:        reg_rdata = geom_q;
         RA_TMO:         reg_rdata = tmo_q;
         RA_HEAD_LO:     reg_rdata = 32'(head_addr);
         default:        reg_rdata = base_hi_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         base_lo_q <= '0;
         base_hi_q <= '0;
         geom_q    <= '0;
         tmo_q     <= '0;
         off_q     <= '0;
         boff_q    <= '0;
         tcnt_q    <= '0;
         dirty_q   <= 1'b0;
      end else begin
         ctl_q <= ctl_d;
         if (done) begin
            off_q  <= ring_wrap ? '0 : off_nx[OFF_W-1:0];
            boff_q <= blk_last ? '0 : boff_nx[BLK_W-1:0];
         end
         if (done)
            tcnt_q <= TMO_W'(tmo_q);
         else if (run && dirty_q && (tcnt_q != '0))
            tcnt_q <= tcnt_q - 1'b1;
         if (evt_irq)   dirty_q <= 1'b0;
         else if (done) dirty_q <= 1'b1;
         if (wr_base_lo) begin
            base_lo_q <= reg_wdata;
            off_q     <= '0;
            boff_q    <= '0;
         end
         if (reg_wr && (reg_addr == RA_BASE_HI)) base_hi_q <= reg_wdata;
         if (reg_wr && (reg_addr == RA_GEOM))    geom_q    <= reg_wdata;
         if (reg_wr && (reg_addr == RA_TMO))     tmo_q     <= reg_wdata;
      end
   end

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CTL_ERR] && !sw_clr[CTL_ERR]) |=> ctl_q[CTL_ERR]);
   // R5
   base_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_base_lo |=> (head_addr ==
         (ADDR_W'($past(reg_wdata[BASE_KEEP-1:0])) & ~ADDR_W'(BYTES - 1))));
   // R6
   blk_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_last |=> irq);
endmodule

// File: rtl/tsr_ring_writer.sv
module tsr_ring_writer #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 4,
   parameter int TMO_W      = 32,
   parameter int GF_W       = 8,
   parameter int BASE_KEEP  = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   output logic              irq
);
   localparam int BYTES = DATA_W / 8;

   if ((DATA_W % 8) != 0 || BYTES < 2) begin : g_bad_data_w
      $error("tsr_ring_writer: DATA_W must be a multiple of 8, at least 16");
   end
   if (ADDR_W > 32 || ADDR_W < 3 * GF_W) begin : g_bad_addr_w
      $error("tsr_ring_writer: ADDR_W must cover the ring and fit 32 bits");
   end
   if (TMO_W > 32 || 3 * GF_W > 32 || BASE_KEEP > 32) begin : g_bad_fields
      $error("tsr_ring_writer: field widths exceed the 32-bit registers");
   end

   logic              run, done, pop, drop, push, full, empty;
   logic [DATA_W-1:0] word, fifo_dout;
   logic [ADDR_W-1:0] head_addr;

   tsr_byte_packer #(.DATA_W(DATA_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .run(run), .in_valid(in_valid),
      .in_data(in_data), .buf_full(full), .word_push(push),
      .word_drop(drop), .word_data(word));

   tsr_hold_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_hold (
      .clk(clk), .rst_n(rst_n), .push(push), .din(word), .pop(pop),
      .dout(fifo_dout), .full(full), .empty(empty));

   tsr_mem_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .run(run), .fifo_empty(empty),
      .fifo_dout(fifo_dout), .head_addr(head_addr), .pop(pop), .done(done),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack));

   tsr_ctl_regs #(.ADDR_W(ADDR_W), .BYTES(BYTES), .TMO_W(TMO_W),
                  .GF_W(GF_W), .BASE_KEEP(BASE_KEEP)) u_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
      .drop(drop), .run(run), .irq(irq), .head_addr(head_addr));
endmodule

// File: tb/tb_tsr_ring_writer.sv
`timescale 1ns/1ps
module tb_tsr_ring_writer;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic        irq;
   logic        ack_en = 1'b1;
   bit          stop_cmp = 1'b0;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2 clk = ~clk;

   tsr_ring_writer #(.FIFO_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq(irq));

   // behavioural reference model
   bit [31:0] m_ctl, m_blo, m_bhi, m_geom, m_tmo, m_off, m_boff, m_tcnt;
   bit        m_dirty, m_busy;
   bit [31:0] m_maddr, m_mdata;
   bit [31:0] m_fifo[$];
   bit [7:0]  m_part[$];

   function automatic bit [31:0] m_head();
      return (m_blo & 32'h3FFF_FFFC) + m_off;
   endfunction

   function automatic bit [31:0] m_read(logic [2:0] a);
      case (a)
         3'd0, 3'd1: return m_ctl;
         3'd2:       return m_blo;
         3'd3:       return m_bhi;
         3'd4:       return m_geom;
         3'd5:       return m_tmo;
         3'd6:       return m_head();
         default:    return m_bhi;
      endcase
   endfunction

   always @(posedge clk) begin : mdl
      bit run, done, load, drop, have_w, blk, tfire;
      bit [31:0] w, blk_b, ring, head, setm, clrm;
      if (!rst_n) begin
         m_ctl = 0; m_blo = 0; m_bhi = 0; m_geom = 0; m_tmo = 0;
         m_off = 0; m_boff = 0; m_tcnt = 0; m_dirty = 0; m_busy = 0;
         m_maddr = 0; m_mdata = 0; m_fifo.delete(); m_part.delete();
      end else begin
         run   = m_ctl[0];
         done  = m_busy && mem_ack;
         load  = !m_busy && run && (m_fifo.size() > 0);
         blk_b = m_geom[7:0] * m_geom[15:8];
         ring  = blk_b * m_geom[31:24];
         head  = m_head();
         drop  = 0; have_w = 0; w = 0;
         if (in_valid && run) begin
            m_part.push_back(in_data);
            if (m_part.size() == 4) begin
               w = {m_part[3], m_part[2], m_part[1], m_part[0]};
               m_part.delete();
               if (m_fifo.size() < DEPTH) have_w = 1; else drop = 1;
            end
         end
         if (load) begin
            m_mdata = m_fifo.pop_front();
            m_maddr = head;
            m_busy  = 1;
         end
         if (have_w) m_fifo.push_back(w);
         if (done) m_busy = 0;
         blk   = 0;
         tfire = !done && run && m_dirty && (m_tcnt == 1);
         if (done) begin
            m_off = (m_off + 4 >= ring) ? 0 : m_off + 4;
            if (m_boff + 4 >= blk_b) begin blk = 1; m_boff = 0; end
            else m_boff = m_boff + 4;
         end
         if (done) m_tcnt = m_tmo;
         else if (run && m_dirty && m_tcnt != 0) m_tcnt = m_tcnt - 1;
         if (blk || tfire) m_dirty = 0; else if (done) m_dirty = 1;
         setm = (reg_wr && reg_addr == 3'd0) ? (reg_wdata & 32'h203) : 0;
         clrm = (reg_wr && reg_addr == 3'd1) ? (reg_wdata & 32'h203) : 0;
         m_ctl = ((m_ctl | setm) & ~clrm) | ((blk || tfire) ? 32'h200 : 0)
                 | (drop ? 32'h2 : 0);
         if (reg_wr) begin
            case (reg_addr)
               3'd2: begin m_blo = reg_wdata; m_off = 0; m_boff = 0; end
               3'd3: m_bhi = reg_wdata;
               3'd4: m_geom = reg_wdata;
               3'd5: m_tmo = reg_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && !stop_cmp) begin
         chk(mem_req == m_busy, "R3 mem_req", 32'(mem_req), 32'(m_busy));
         if (m_busy) begin
            chk(mem_addr == m_maddr, "R4 R11 mem_addr", mem_addr, m_maddr);
            chk(mem_wdata == m_mdata, "R3 R11 mem_wdata", mem_wdata, m_mdata);
         end
         chk(irq == m_ctl[9], "R6 R7 irq", 32'(irq), 32'(m_ctl[9]));
         chk(reg_rdata == m_read(reg_addr), "R2 reg_rdata", reg_rdata, m_read(reg_addr));
      end
   end

   always @(negedge clk) begin
      #1;
      mem_ack = ack_en && mem_req;
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic send(int n, logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = seed + 8'(i);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic summary();
      stop_cmp = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      summary();
   end

   initial begin
      logic [31:0] v;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      rd(3'd0, v); chk(v == 32'h0, "R1 ctl after reset", v, 32'h0);
      rd(3'd6, v); chk(v == 32'h0, "R1 head after reset", v, 32'h0);
      chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 32'h0);
      chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);

      // R2 set and clear ports
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd1, v); chk(v == 32'h203, "R2 set port mask", v, 32'h203);
      wr(3'd1, 32'h0000_0202);
      rd(3'd0, v); chk(v == 32'h001, "R2 clear port", v, 32'h001);
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd0, v); chk(v == 32'h000, "R2 clear all", v, 32'h000);

      // R5 base handling, R4 geometry: 8-byte packets, 2 per block, 3 blocks
      wr(3'd2, 32'h4000_0103);
      wr(3'd3, 32'h0000_0055);
      rd(3'd6, v); chk(v == 32'h100, "R5 head at base", v, 32'h100);
      rd(3'd7, v); chk(v == 32'h55, "R5 head high", v, 32'h55);
      wr(3'd4, (32'd3 << 24) | (32'd2 << 8) | 32'd8);
      wr(3'd0, 32'h1);

      // R3 R6 one block
      send(16, 8'h10);
      tick(12);
      rd(3'd6, v); chk(v == 32'h110, "R3 head after block", v, 32'h110);
      chk(irq == 1'b1, "R6 irq after block", 32'(irq), 32'h1);
      wr(3'd1, 32'h200);
      rd(3'd0, v); chk(v == 32'h001, "R6 irq acknowledged", v, 32'h001);

      // R4 wrap
      send(32, 8'h40);
      tick(12);
      rd(3'd6, v); chk(v == 32'h100, "R4 head wrapped", v, 32'h100);

      // R7 timeout
      wr(3'd1, 32'h200);
      wr(3'd5, 32'd10);
      send(4, 8'h80);
      tick(4);
      chk(irq == 1'b0, "R7 irq before expiry", 32'(irq), 32'h0);
      tick(30);
      rd(3'd0, v); chk(v == 32'h201, "R7 irq on timeout", v, 32'h201);
      wr(3'd1, 32'h200);
      tick(40);
      rd(3'd0, v); chk(v == 32'h001, "R7 no timeout without data", v, 32'h001);

      // R9 stop and resume
      wr(3'd1, 32'h1);
      send(8, 8'h90);
      tick(10);
      rd(3'd6, v); chk(v == 32'h104, "R9 bytes ignored while stopped", v, 32'h104);
      wr(3'd0, 32'h1);
      send(4, 8'hA0);
      tick(30);
      rd(3'd6, v); chk(v == 32'h108, "R3 R9 resume from head", v, 32'h108);

      // R9 in-flight write completes after RUN clears
      ack_en = 1'b0;
      send(4, 8'hB0);
      tick(3);
      chk(mem_req == 1'b1, "R11 request held", 32'(mem_req), 32'h1);
      wr(3'd1, 32'h1);
      tick(3);
      ack_en = 1'b1;
      tick(5);
      rd(3'd6, v); chk(v == 32'h10C, "R9 in-flight word completes", v, 32'h10C);
      wr(3'd0, 32'h1);
      wr(3'd1, 32'h200);

      // R8 overflow
      ack_en = 1'b0;
      send(4 * (DEPTH + 2), 8'hC0);
      tick(2);
      rd(3'd0, v); chk(v[1] == 1'b1, "R8 overflow sets error", 32'(v[1]), 32'h1);
      wr(3'd1, 32'h2);
      rd(3'd0, v); chk(v[1] == 1'b0, "R8 error cleared", 32'(v[1]), 32'h0);

      // R10 overflow and clear in the same cycle
      send(3, 8'hD0);
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hD3;
      reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h2;
      @(negedge clk);
      in_valid = 1'b0; reg_wr = 1'b0;
      rd(3'd0, v); chk(v[1] == 1'b1, "R10 set wins over clear", 32'(v[1]), 32'h1);

      ack_en = 1'b1;
      tick(40);
      rd(3'd6, v); chk(v == 32'h120, "R8 dropped words not written", v, 32'h120);
      rd(3'd0, v); chk(v[1] == 1'b1, "R8 error sticky after drain", 32'(v[1]), 32'h1);
      wr(3'd1, 32'h2);
      rd(3'd0, v); chk(v[1] == 1'b0, "R8 error cleared by port", 32'(v[1]), 32'h0);
      tick(4);
      summary();
   end
endmodule